// File: doc/BRIEF.md
# Chained-Buffer DMA Channel Pair

This block moves data between one peripheral's data registers and system memory without processor help. It has two independent directions. Receive copies words from the peripheral into memory. Transmit copies words from memory to the peripheral.

Each direction keeps two buffer descriptors, and each descriptor is a pointer and a count. The first is the buffer being worked on now. The second is queued to follow it. When the working buffer runs out, the queued one takes its place on the next cycle. Software can therefore refill the queued slot while the working buffer drains, and the stream runs across buffers without processor action. All eight descriptor fields, a command word and a status word sit in a small word-indexed register window.

The peripheral raises a one-cycle strobe for each word it has ready (receive) or each time its transmit register is free (transmit). A single sequencer serves the requests on a request/acknowledge memory port.

Top module: `dma_chain_pair`

## Requirements
- R1: After reset all descriptor fields read 0, both directions are disabled, `mem_req` and `tx_valid` are low, and all four buffer flags read 1.
- R2: The register window is addressed by word index and each field can be read back. The map is:
  - index 0: receive current pointer
  - index 1: receive current count
  - index 2: transmit current pointer
  - index 3: transmit current count
  - index 4: receive queued pointer
  - index 5: receive queued count
  - index 6: transmit queued pointer
  - index 7: transmit queued count
  - index 8: command word, which reads 0
  - index 9: status word, where writes are ignored

  Counts keep only the low 16 bits of the written value.
- R3: In the command word, bit 0 enables receive, bit 1 disables receive, bit 8 enables transmit and bit 9 disables transmit. A disable bit wins over an enable bit set in the same write, and a 0 bit changes nothing. In the status word, bit 0 reads 1 while receive is enabled and bit 8 reads 1 while transmit is enabled.
- R4: Each completed transfer decrements the current count by one. It also advances the current pointer by a step set by `xfer_size`: 0 gives 1, 1 gives 2, and 2 or 3 give 4.
- R5: A receive strobe sampled at edge k produces a memory write. The write is visible after edge k+2, with `mem_we`=1, `mem_addr` equal to the receive current pointer, and `mem_wdata` equal to the strobed `rx_data`. With an immediate acknowledge this occupies the sequencer for two cycles.
- R6: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R7: Whenever a current count is 0 and its queued count is not 0, the next edge makes three changes:
  - the queued pointer is copied into the current pointer;
  - the queued count is copied into the current count;
  - the queued count is cleared to 0.
- R8: The end flag of a direction is 1 while its current count is 0. Its all-done flag is 1 while both its current and queued counts are 0.
- R9: A direction whose current count is 0 issues no memory request, even when enabled. A strobe received in that state stays pending. Writing a nonzero queued count reloads the descriptor on the following edge, and the pending transfer then proceeds.
- R10: When both directions have a request pending in the same cycle, receive is served first.
- R11: A strobe that arrives while its direction is disabled is dropped. A later enable does not cause a transfer for it.
- R12: A transmit strobe sampled at edge k produces a memory read visible after edge k+1, with `mem_we`=0. The edge on which `mem_ack` is sampled high is followed by a one-cycle `tx_valid` pulse, with `tx_data` equal to the word read.

Register writes take priority over hardware updates made on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_word` (combinational) |
| xfer_size | input | 2 | Transfer size: 0 byte, 1 half-word, 2 or 3 word |
| rx_req | input | 1 | Peripheral has a received word (one-cycle strobe) |
| rx_data | input | 32 | Received word, valid with `rx_req` |
| tx_req | input | 1 | Peripheral transmit register is free (one-cycle strobe) |
| tx_data | output | 32 | Word delivered to the peripheral |
| tx_valid | output | 1 | One-cycle pulse, `tx_data` valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write (receive), 0 for read (transmit) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory accepts the access this cycle |
| rx_buf_end | output | 1 | Receive current count is 0 |
| rx_bufs_done | output | 1 | Receive current and queued counts are 0 |
| tx_buf_end | output | 1 | Transmit current count is 0 |
| tx_bufs_done | output | 1 | Transmit current and queued counts are 0 |

## Verification
The assertions rely on three assumptions about the environment:
- The memory raises `mem_ack` only while `mem_req` is high.
- Software does not rewrite a direction's current count while that direction's access is outstanding.
- The count-reload property assumes no register write is made in the cycle it checks.

The stimulus stays within these assumptions. The bench drives the acknowledge as a function of `mem_req` and a stall enable. It changes descriptors only while the sequencer is idle. It issues strobes only between register writes.

// File: rtl/dma_chain_pkg.sv
// Package: shared constants, register indices and state type for the
// chained-buffer DMA channel pair.
// Assumes: two directions, word-indexed register window of ten words.
package dma_chain_pkg;

    localparam int NUM_DIR = 2;
    localparam int DIR_RX  = 0;
    localparam int DIR_TX  = 1;
    localparam int REG_IW  = 4;

    // Per-direction word indices follow 2*d (+1) for current, 4+2*d (+1) for queued
    localparam logic [REG_IW-1:0] REG_CMD  = 4'd8;
    localparam logic [REG_IW-1:0] REG_STAT = 4'd9;

    // Command and status bit position of a direction: enable at 8*d, disable at 8*d+1
    localparam int CMD_STRIDE = 8;

    typedef enum logic [1:0] {
        SQ_IDLE     = 2'd0,
        SQ_RX_STAGE = 2'd1,
        SQ_RX_WRITE = 2'd2,
        SQ_TX_READ  = 2'd3
    } seq_state_t;

    // Address step for a transfer size code
    function automatic logic [2:0] size_step(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_desc_dir.sv
// Module: one direction's descriptor set (current and queued pointer/count)
// plus its enable bit. Advances on a completed transfer, reloads the queued
// descriptor into the current one when the current count is zero.
// Assumes: AW and CW are not wider than DW; register writes beat hardware
// updates on the same edge.
module dma_desc_dir #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cur_ptr,
    input  logic          wr_cur_cnt,
    input  logic          wr_nxt_ptr,
    input  logic          wr_nxt_cnt,
    input  logic [DW-1:0] wdata,
    input  logic          cmd_en,
    input  logic          cmd_dis,
    input  logic          advance,
    input  logic [2:0]    step,
    output logic [AW-1:0] cur_ptr,
    output logic [CW-1:0] cur_cnt,
    output logic [AW-1:0] nxt_ptr,
    output logic [CW-1:0] nxt_cnt,
    output logic          chan_on,
    output logic          buf_end,
    output logic          bufs_done,
    output logic          active
);

    logic cur_zero;
    logic nxt_zero;
    logic reload_go;
    logic step_go;

    assign cur_zero  = (cur_cnt == '0);
    assign nxt_zero  = (nxt_cnt == '0);
    assign reload_go = cur_zero && !nxt_zero && !wr_cur_ptr && !wr_cur_cnt;
    assign step_go   = advance && !cur_zero;

    assign buf_end   = cur_zero;
    assign bufs_done = cur_zero && nxt_zero;
    assign active    = chan_on && !cur_zero;

    // Current pointer: write, advance by step, or take the queued pointer
    always_ff @(posedge clk) begin
        if (!rst_n)          cur_ptr <= '0;
        else if (wr_cur_ptr) cur_ptr <= wdata[AW-1:0];
        else if (step_go)    cur_ptr <= cur_ptr + AW'(step);
        else if (reload_go)  cur_ptr <= nxt_ptr;
    end

    // Current count: write, decrement, or take the queued count
    always_ff @(posedge clk) begin
        if (!rst_n)          cur_cnt <= '0;
        else if (wr_cur_cnt) cur_cnt <= wdata[CW-1:0];
        else if (step_go)    cur_cnt <= cur_cnt - CW'(1);
        else if (reload_go)  cur_cnt <= nxt_cnt;
    end

    // Queued pointer: software only
    always_ff @(posedge clk) begin
        if (!rst_n)          nxt_ptr <= '0;
        else if (wr_nxt_ptr) nxt_ptr <= wdata[AW-1:0];
    end

    // Queued count: software write, cleared once consumed by a reload
    always_ff @(posedge clk) begin
        if (!rst_n)          nxt_cnt <= '0;
        else if (wr_nxt_cnt) nxt_cnt <= wdata[CW-1:0];
        else if (reload_go)  nxt_cnt <= '0;
    end

    // Enable bit: disable wins over enable in the same command
    always_ff @(posedge clk) begin
        if (!rst_n)       chan_on <= 1'b0;
        else if (cmd_dis) chan_on <= 1'b0;
        else if (cmd_en)  chan_on <= 1'b1;
    end

endmodule

// File: rtl/dma_xfer_seq.sv
// Module: request latches and the shared transfer sequencer. Receive takes
// a staging cycle and a write cycle; transmit takes one read cycle. Receive
// wins when both are pending.
// Assumes: peripheral strobes are one cycle wide; memory holds mem_ack low
// when mem_req is low.
module dma_xfer_seq
    import dma_chain_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DIR-1:0] chan_on,
    input  logic [NUM_DIR-1:0] active,
    input  logic [AW-1:0]      rx_cur_ptr,
    input  logic [AW-1:0]      tx_cur_ptr,
    input  logic               rx_req,
    input  logic [DW-1:0]      rx_data,
    input  logic               tx_req,
    input  logic               mem_ack,
    input  logic [DW-1:0]      mem_rdata,
    output logic [NUM_DIR-1:0] advance,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    output logic [DW-1:0]      tx_data,
    output logic               tx_valid
);

    seq_state_t         state;
    logic [NUM_DIR-1:0] strobe;
    logic [NUM_DIR-1:0] pend;
    logic [NUM_DIR-1:0] grant;
    logic [DW-1:0]      rx_hold;
    logic [AW-1:0]      addr_q;
    logic [DW-1:0]      wdata_q;

    assign strobe[DIR_RX] = rx_req;
    assign strobe[DIR_TX] = tx_req;

    // Grant selection in idle: receive first
    always_comb begin
        grant = '0;
        if (state == SQ_IDLE) begin
            if (pend[DIR_RX] && active[DIR_RX])      grant[DIR_RX] = 1'b1;
            else if (pend[DIR_TX] && active[DIR_TX]) grant[DIR_TX] = 1'b1;
        end
    end

    // Per-direction pending latch: dropped while disabled, cleared on grant
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_pend
        always_ff @(posedge clk) begin
            if (!rst_n || !chan_on[d]) pend[d] <= 1'b0;
            else if (strobe[d])        pend[d] <= 1'b1;
            else if (grant[d])         pend[d] <= 1'b0;
        end
    end

    // Receive holding register captured with the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)                        rx_hold <= '0;
        else if (rx_req && chan_on[DIR_RX]) rx_hold <= rx_data;
    end

    // Sequencer state and latched access fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (grant[DIR_RX]) begin
                        state   <= SQ_RX_STAGE;
                        addr_q  <= rx_cur_ptr;
                        wdata_q <= rx_hold;
                    end else if (grant[DIR_TX]) begin
                        state  <= SQ_TX_READ;
                        addr_q <= tx_cur_ptr;
                    end
                end
                SQ_RX_STAGE: state <= SQ_RX_WRITE;
                SQ_RX_WRITE: if (mem_ack) state <= SQ_IDLE;
                SQ_TX_READ:  if (mem_ack) state <= SQ_IDLE;
                default:     state <= SQ_IDLE;
            endcase
        end
    end

    // Transmit data register and its one-cycle valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data  <= '0;
            tx_valid <= 1'b0;
        end else begin
            tx_valid <= (state == SQ_TX_READ) && mem_ack;
            if ((state == SQ_TX_READ) && mem_ack) tx_data <= mem_rdata;
        end
    end

    assign mem_req         = (state == SQ_RX_WRITE) || (state == SQ_TX_READ);
    assign mem_we          = (state == SQ_RX_WRITE);
    assign mem_addr        = addr_q;
    assign mem_wdata       = wdata_q;
    assign advance[DIR_RX] = (state == SQ_RX_WRITE) && mem_ack;
    assign advance[DIR_TX] = (state == SQ_TX_READ) && mem_ack;

endmodule

// File: rtl/dma_chain_pair.sv
// Module: top of the chained-buffer DMA channel pair. Decodes the register
// window, instantiates one descriptor set per direction and the shared
// sequencer, and forms read data and buffer flags.
// Assumes: DW is at least AW and CW; reg_rdata is combinational.
module dma_chain_pair
    import dma_chain_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_IW-1:0] reg_word,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [1:0]        xfer_size,
    input  logic              rx_req,
    input  logic [DW-1:0]     rx_data,
    input  logic              tx_req,
    output logic [DW-1:0]     tx_data,
    output logic              tx_valid,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ack,
    output logic              rx_buf_end,
    output logic              rx_bufs_done,
    output logic              tx_buf_end,
    output logic              tx_bufs_done
);

    logic [AW-1:0]      cur_ptr [NUM_DIR];
    logic [CW-1:0]      cur_cnt [NUM_DIR];
    logic [AW-1:0]      nxt_ptr [NUM_DIR];
    logic [CW-1:0]      nxt_cnt [NUM_DIR];
    logic [NUM_DIR-1:0] chan_on;
    logic [NUM_DIR-1:0] buf_end;
    logic [NUM_DIR-1:0] bufs_done;
    logic [NUM_DIR-1:0] active;
    logic [NUM_DIR-1:0] advance;
    logic [2:0]         step;
    logic               cmd_wr;

    assign step   = size_step(xfer_size);
    assign cmd_wr = reg_wr && (reg_word == REG_CMD);

    // One descriptor set per direction
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        dma_desc_dir #(.AW(AW), .CW(CW), .DW(DW)) u_desc (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_cur_ptr (reg_wr && (reg_word == REG_IW'(2*d))),
            .wr_cur_cnt (reg_wr && (reg_word == REG_IW'(2*d + 1))),
            .wr_nxt_ptr (reg_wr && (reg_word == REG_IW'(4 + 2*d))),
            .wr_nxt_cnt (reg_wr && (reg_word == REG_IW'(5 + 2*d))),
            .wdata      (reg_wdata),
            .cmd_en     (cmd_wr && reg_wdata[CMD_STRIDE*d]),
            .cmd_dis    (cmd_wr && reg_wdata[CMD_STRIDE*d + 1]),
            .advance    (advance[d]),
            .step       (step),
            .cur_ptr    (cur_ptr[d]),
            .cur_cnt    (cur_cnt[d]),
            .nxt_ptr    (nxt_ptr[d]),
            .nxt_cnt    (nxt_cnt[d]),
            .chan_on    (chan_on[d]),
            .buf_end    (buf_end[d]),
            .bufs_done  (bufs_done[d]),
            .active     (active[d])
        );
    end

    dma_xfer_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_on    (chan_on),
        .active     (active),
        .rx_cur_ptr (cur_ptr[DIR_RX]),
        .tx_cur_ptr (cur_ptr[DIR_TX]),
        .rx_req     (rx_req),
        .rx_data    (rx_data),
        .tx_req     (tx_req),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .advance    (advance),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid)
    );

    // Read-data multiplexer over the register window
    always_comb begin
        reg_rdata = '0;
        for (int d = 0; d < NUM_DIR; d++) begin
            if (reg_word == REG_IW'(2*d))     reg_rdata = DW'(cur_ptr[d]);
            if (reg_word == REG_IW'(2*d + 1)) reg_rdata = DW'(cur_cnt[d]);
            if (reg_word == REG_IW'(4 + 2*d)) reg_rdata = DW'(nxt_ptr[d]);
            if (reg_word == REG_IW'(5 + 2*d)) reg_rdata = DW'(nxt_cnt[d]);
        end
        if (reg_word == REG_STAT) begin
            for (int d = 0; d < NUM_DIR; d++) reg_rdata[CMD_STRIDE*d] = chan_on[d];
        end
    end

    assign rx_buf_end   = buf_end[DIR_RX];
    assign rx_bufs_done = bufs_done[DIR_RX];
    assign tx_buf_end   = buf_end[DIR_TX];
    assign tx_bufs_done = bufs_done[DIR_TX];

endmodule

// File: rtl/dma_chain_pair_chk.sv
// Module: property checker for dma_chain_pair, attached by bind.
// Assumes: mem_ack only with mem_req; current counts are not rewritten
// while an access of that direction is outstanding.
module dma_chain_pair_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [3:0]  reg_word,
    input logic [31:0] reg_wdata,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        tx_valid,
    input logic        rx_buf_end,
    input logic        rx_bufs_done,
    input logic        tx_buf_end,
    input logic        tx_bufs_done,
    input logic [1:0]  chan_on
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R6

    AST_RX_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_word == 4'd8 && reg_wdata[1] |=> !chan_on[0]); // R3

    AST_TX_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_word == 4'd8 && reg_wdata[9] |=> !chan_on[1]); // R3

    AST_RX_NEEDS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !rx_buf_end); // R9

    AST_TX_NEEDS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> !tx_buf_end); // R9

    AST_RX_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_buf_end && !rx_bufs_done && !reg_wr |=> !rx_buf_end); // R7

    AST_TX_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_buf_end && !tx_bufs_done && !reg_wr |=> !tx_buf_end); // R7

    AST_TX_VALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(mem_req && !mem_we && mem_ack)); // R12

    AST_TX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid); // R12

endmodule

bind dma_chain_pair dma_chain_pair_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_word     (reg_word),
    .reg_wdata    (reg_wdata),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .tx_valid     (tx_valid),
    .rx_buf_end   (rx_buf_end),
    .rx_bufs_done (rx_bufs_done),
    .tx_buf_end   (tx_buf_end),
    .tx_bufs_done (tx_bufs_done),
    .chan_on      (chan_on)
);

// File: tb/dma_chain_pair_bench.sv
// Directed bench for dma_chain_pair: one task per scenario, each checking
// its own results at falling clock edges.
module dma_chain_pair_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk;
    logic        rst_n;
    logic        reg_wr;
    logic [3:0]  reg_word;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [1:0]  xfer_size;
    logic        rx_req;
    logic [31:0] rx_data;
    logic        tx_req;
    logic [31:0] tx_data;
    logic        tx_valid;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;
    logic        rx_buf_end;
    logic        rx_bufs_done;
    logic        tx_buf_end;
    logic        tx_bufs_done;

    logic        ack_en;
    logic [31:0] last_waddr;
    logic [31:0] last_wdata;
    int          checks;
    int          errors;
    bit          done;

    dma_chain_pair u_dma_chain_pair (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_size(xfer_size),
        .rx_req(rx_req), .rx_data(rx_data), .tx_req(tx_req), .tx_data(tx_data),
        .tx_valid(tx_valid), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .rx_buf_end(rx_buf_end), .rx_bufs_done(rx_bufs_done),
        .tx_buf_end(tx_buf_end), .tx_bufs_done(tx_bufs_done)
    );

    // Memory model: acknowledge follows request unless stalled; read data is the inverted address
    assign mem_ack   = mem_req && ack_en;
    assign mem_rdata = ~mem_addr;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Record completed memory writes
    always @(posedge clk) begin
        if (mem_req && mem_ack && mem_we) begin
            last_waddr <= mem_addr;
            last_wdata <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] w, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_word = w; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] w, output logic [31:0] v);
        reg_word = w;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse(input bit do_rx, input bit do_tx, input logic [31:0] d);
        @(negedge clk);
        rx_req = do_rx; tx_req = do_tx; rx_data = d;
        @(negedge clk);
        rx_req = 1'b0; tx_req = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        logic [31:0] v;
        chk(!mem_req && !tx_valid, "R1 idle outputs", {mem_req, tx_valid}, 0);
        chk(rx_buf_end && rx_bufs_done && tx_buf_end && tx_bufs_done, "R1 flags",
            {rx_buf_end, rx_bufs_done, tx_buf_end, tx_bufs_done}, 4'hf);
        reg_read(4'd9, v); chk(v == 0, "R1 status", v, 0);
        reg_read(4'd0, v); chk(v == 0, "R1 rx pointer", v, 0);
    endtask

    // R2: register window readback and count width
    task automatic t_regs();
        logic [31:0] v;
        reg_write(4'd0, 32'h1111_0000);
        reg_write(4'd2, 32'h2222_0000);
        reg_write(4'd1, 32'h1234_5678);
        reg_write(4'd3, 32'h0000_0033);
        reg_write(4'd4, 32'h4444_0000);
        reg_write(4'd6, 32'h6666_0000);
        reg_write(4'd5, 32'h0000_0055);
        reg_write(4'd7, 32'hABCD_0077);
        reg_write(4'd9, 32'hFFFF_FFFF);
        reg_read(4'd0, v); chk(v == 32'h1111_0000, "R2 idx0", v, 32'h1111_0000);
        reg_read(4'd1, v); chk(v == 32'h5678, "R2 idx1 16-bit", v, 32'h5678);
        reg_read(4'd2, v); chk(v == 32'h2222_0000, "R2 idx2", v, 32'h2222_0000);
        reg_read(4'd3, v); chk(v == 32'h33, "R2 idx3", v, 32'h33);
        reg_read(4'd4, v); chk(v == 32'h4444_0000, "R2 idx4", v, 32'h4444_0000);
        reg_read(4'd5, v); chk(v == 32'h55, "R2 idx5", v, 32'h55);
        reg_read(4'd6, v); chk(v == 32'h6666_0000, "R2 idx6", v, 32'h6666_0000);
        reg_read(4'd7, v); chk(v == 32'h77, "R2 idx7", v, 32'h77);
        reg_read(4'd9, v); chk(v == 0, "R2 status write ignored", v, 0);
        reg_read(4'd8, v); chk(v == 0, "R2 command reads 0", v, 0);
        reg_write(4'd5, 0); reg_write(4'd7, 0);
        reg_write(4'd1, 0); reg_write(4'd3, 0);
    endtask

    // R3: enable/disable command semantics
    task automatic t_ctrl();
        logic [31:0] v;
        reg_write(4'd8, 32'h0303);
        reg_read(4'd9, v); chk(v == 0, "R3 disable wins", v, 0);
        reg_write(4'd8, 32'h0101);
        reg_read(4'd9, v); chk(v == 32'h101, "R3 enable both", v, 32'h101);
        reg_write(4'd8, 32'h0);
        reg_read(4'd9, v); chk(v == 32'h101, "R3 zero no effect", v, 32'h101);
        reg_write(4'd8, 32'h0002);
        reg_read(4'd9, v); chk(v == 32'h100, "R3 rx disable", v, 32'h100);
        reg_write(4'd8, 32'h0200);
        reg_read(4'd9, v); chk(v == 0, "R3 tx disable", v, 0);
    endtask

    // R4, R5, R8: receive path timing and pointer stepping
    task automatic t_rx();
        logic [31:0] v;
        xfer_size = 2'd2;
        reg_write(4'd0, 32'h0000_1000);
        reg_write(4'd1, 32'd2);
        reg_write(4'd8, 32'h0001);
        pulse(1'b1, 1'b0, 32'hA5A5_0001);
        @(negedge clk); chk(!mem_req, "R5 no request before k+2", mem_req, 0);
        @(negedge clk);
        chk(mem_req && mem_we && mem_addr == 32'h1000 && mem_wdata == 32'hA5A5_0001,
            "R5 write after k+2", mem_addr, 32'h1000);
        @(negedge clk);
        chk(last_waddr == 32'h1000 && last_wdata == 32'hA5A5_0001, "R5 write data", last_wdata, 32'hA5A5_0001);
        reg_read(4'd0, v); chk(v == 32'h1004, "R4 word step", v, 32'h1004);
        reg_read(4'd1, v); chk(v == 32'd1, "R4 count decrement", v, 1);
        xfer_size = 2'd1;
        pulse(1'b1, 1'b0, 32'h0000_BEEF);
        repeat (3) @(negedge clk);
        chk(last_waddr == 32'h1004, "R5 second address", last_waddr, 32'h1004);
        reg_read(4'd0, v); chk(v == 32'h1006, "R4 half step", v, 32'h1006);
        chk(rx_buf_end && rx_bufs_done, "R8 rx flags at zero", {rx_buf_end, rx_bufs_done}, 2'b11);
    endtask

    // R12, R4: transmit timing and data delivery
    task automatic t_tx();
        logic [31:0] v;
        xfer_size = 2'd0;
        reg_write(4'd2, 32'h0000_2000);
        reg_write(4'd3, 32'd3);
        reg_write(4'd8, 32'h0100);
        pulse(1'b0, 1'b1, 0);
        chk(!mem_req, "R12 no read at k", mem_req, 0);
        @(negedge clk);
        chk(mem_req && !mem_we && mem_addr == 32'h2000, "R12 read after k+1", mem_addr, 32'h2000);
        @(negedge clk);
        chk(tx_valid && tx_data == ~32'h2000, "R12 tx data", tx_data, ~32'h2000);
        @(negedge clk);
        chk(!tx_valid, "R12 single pulse", tx_valid, 0);
        reg_read(4'd2, v); chk(v == 32'h2001, "R4 byte step", v, 32'h2001);
    endtask

    // R6: request held through a stalled acknowledge
    task automatic t_stall();
        bit ok;
        ack_en = 1'b0;
        pulse(1'b0, 1'b1, 0);
        @(negedge clk);
        ok = 1'b1;
        for (int i = 0; i < 3; i++) begin
            if (!(mem_req && !mem_we && mem_addr == 32'h2001 && !tx_valid)) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok && mem_req, "R6 request held", mem_addr, 32'h2001);
        ack_en = 1'b1;
        @(negedge clk);
        chk(tx_valid && tx_data == ~32'h2001, "R6 completes after ack", tx_data, ~32'h2001);
    endtask

    // R7, R8: automatic reload after the current buffer runs out
    task automatic t_chain();
        logic [31:0] v;
        reg_write(4'd6, 32'h0000_3000);
        reg_write(4'd7, 32'd2);
        chk(!tx_buf_end, "R8 end low while count nonzero", tx_buf_end, 0);
        pulse(1'b0, 1'b1, 0);
        @(negedge clk);
        @(negedge clk);
        chk(tx_buf_end && !tx_bufs_done, "R8 end set, queued remains", {tx_buf_end, tx_bufs_done}, 2'b10);
        @(negedge clk);
        chk(!tx_buf_end, "R7 reload clears end", tx_buf_end, 0);
        reg_read(4'd3, v); chk(v == 32'd2, "R7 count copied", v, 2);
        reg_read(4'd2, v); chk(v == 32'h3000, "R7 pointer copied", v, 32'h3000);
        reg_read(4'd7, v); chk(v == 0, "R7 queued count cleared", v, 0);
    endtask

    // R9: no requests when both counts are zero; resume after refill
    task automatic t_drain();
        logic [31:0] v;
        int seen;
        bit got;
        for (int i = 0; i < 2; i++) begin
            pulse(1'b0, 1'b1, 0);
            repeat (3) @(negedge clk);
        end
        chk(tx_buf_end && tx_bufs_done, "R8 tx all done", {tx_buf_end, tx_bufs_done}, 2'b11);
        pulse(1'b0, 1'b1, 0);
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            if (mem_req) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R9 no request when exhausted", seen, 0);
        reg_write(4'd7, 32'd1);
        @(negedge clk);
        reg_read(4'd3, v); chk(v == 32'd1, "R9 reload on following edge", v, 1);
        reg_read(4'd2, v); chk(v == 32'h3000, "R9 reloaded pointer", v, 32'h3000);
        got = 1'b0;
        for (int i = 0; i < 6 && !got; i++) begin
            @(negedge clk);
            if (tx_valid) got = 1'b1;
        end
        chk(got && tx_data == ~32'h3000, "R9 pending transfer resumes", tx_data, ~32'h3000);
    endtask

    // R10: receive served before transmit
    task automatic t_prio();
        int n;
        xfer_size = 2'd2;
        reg_write(4'd0, 32'h0000_4000);
        reg_write(4'd1, 32'd1);
        reg_write(4'd2, 32'h0000_5000);
        reg_write(4'd3, 32'd1);
        pulse(1'b1, 1'b1, 32'h1234_0000);
        n = 0;
        while (!mem_req && n < 10) begin @(negedge clk); n++; end
        chk(mem_req && mem_we && mem_addr == 32'h4000, "R10 receive first", mem_addr, 32'h4000);
        n = 0;
        while (mem_req && n < 10) begin @(negedge clk); n++; end
        n = 0;
        while (!mem_req && n < 10) begin @(negedge clk); n++; end
        chk(mem_req && !mem_we && mem_addr == 32'h5000, "R10 transmit second", mem_addr, 32'h5000);
        repeat (3) @(negedge clk);
    endtask

    // R11: strobe while disabled is dropped
    task automatic t_ignore();
        logic [31:0] v;
        int seen;
        reg_write(4'd8, 32'h0200);
        reg_write(4'd3, 32'd3);
        pulse(1'b0, 1'b1, 0);
        reg_write(4'd8, 32'h0100);
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            if (mem_req) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R11 no transfer for dropped strobe", seen, 0);
        reg_read(4'd3, v); chk(v == 32'd3, "R11 count untouched", v, 3);
    endtask

    initial begin
        done = 1'b0;
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual %0d expected 0", WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        checks = 0; errors = 0;
        rst_n = 1'b0; reg_wr = 1'b0; reg_word = '0; reg_wdata = '0;
        xfer_size = 2'd0; rx_req = 1'b0; rx_data = '0; tx_req = 1'b0; ack_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_ctrl();
        t_rx();
        t_tx();
        t_stall();
        t_chain();
        t_drain();
        t_prio();
        t_ignore();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule